// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Access Rights

The block holds recently used page table entries and maps a 14-bit virtual address to a 12-bit physical address. The lookup is combinational and reads registered entries. The virtual page number is the address above the 6-bit page offset. Its low two bits select one of four sets, and its upper six bits are compared with the tag held in each of the four ways of that set. When a valid way matches, the stored physical page number is joined to the unchanged page offset.

Each entry carries read, write and execute rights. A matching entry that does not allow the requested kind of access produces a protection fault, and no translation is returned. When no way matches, the block raises a miss. An external page walker then fetches the entry and writes it back through the fill port. If the walk reports a page fault, nothing is installed.

A flush input empties the whole structure in one cycle, which is what a context switch needs. Within a set, a fill goes to the lowest invalid way. When every way in the set is valid, a per-set rotating pointer chooses the victim.

Top module: `xlat_tlb`

## Requirements
- R1: The virtual page number is `req_vaddr[13:6]`. Its bits [1:0] select one of 4 sets and bits [7:2] form the 6-bit tag. Each set has 4 ways, so there are 16 entries in total. A fill uses the same split on `fill_vpn`.
- R2: When `req_valid` is high and a valid way in the selected set holds the tag, and the access is permitted, `resp_hit` is high and `resp_paddr` = {stored physical page number, `req_vaddr[5:0]`}.
- R3: When `req_valid` is high and no valid way in the selected set holds the tag, `resp_miss` is high and `resp_paddr` is 0.
- R4: `req_acc` encodes 0 = read, 1 = write, 2 = execute and 3 = reserved. The reserved code is always denied. The rights are stored from `fill_perm`, with bit 2 = read, bit 1 = write and bit 0 = execute. A matching entry that denies the access raises `resp_prot_fault`, keeps `resp_hit` low and drives `resp_paddr` to 0.
- R5: At most one of `resp_hit`, `resp_miss` and `resp_prot_fault` is high. All three are low while `req_valid` is low.
- R6: A fill with `fill_valid` high and `fill_fault` low is visible to a lookup in the next cycle. If the set already holds that tag, the fill overwrites that way.
- R7: A fill with `fill_fault` high installs nothing.
- R8: A fill of a new tag goes to the lowest-numbered invalid way of its set. If all four ways are valid, it replaces the way named by that set's rotating pointer. The pointer is 0 after reset and advances by one, modulo 4, only on such an eviction.
- R9: `flush` invalidates every entry in one cycle. A fill in the same cycle is dropped. The rotating pointers keep their values.
- R10: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 14 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| resp_hit | output | 1 | Translation found and permitted |
| resp_miss | output | 1 | No entry matched; walker needed |
| resp_prot_fault | output | 1 | Entry matched but access denied |
| resp_paddr | output | 12 | Physical address on a hit, else 0 |
| fill_valid | input | 1 | Walker returns an entry |
| fill_vpn | input | 8 | Virtual page number of the returned entry |
| fill_ppn | input | 6 | Physical page number of the returned entry |
| fill_perm | input | 3 | Rights: bit 2 read, bit 1 write, bit 0 execute |
| fill_fault | input | 1 | Walk ended in a page fault; do not install |

## Verification
The assertions take for granted that the request inputs carry known values whenever `req_valid` is high. The fill-visibility property also relies on the walker never returning two different entries for one page number, so that each set holds a tag at most once. The stimulus keeps to both conditions. It drives every input from a task at the falling edge. It installs a repeated page number only as a deliberate overwrite of the same tag, which the overwrite rule turns into an update in place and never into a duplicate.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 2;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 0;

endpackage

// File: rtl/xlat_tlb_perm.sv
module xlat_tlb_perm
  import xlat_tlb_pkg::*;
(
  input  logic [PERM_W-1:0] rights,
  input  logic [1:0]        acc,
  output logic              allow
);

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  allow = rights[PERM_RD];
      ACC_WRITE: allow = rights[PERM_WR];
      ACC_EXEC:  allow = rights[PERM_EX];
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             evict,
  output logic [WAY_W-1:0] way_idx
);

  logic [WAY_W-1:0] ptr_q, ptr_d;
  logic [WAY_W-1:0] free_idx;
  logic             set_full;

  assign set_full = &valid_vec;

  // lowest invalid way wins: scan downwards so the last assignment is the lowest
  always_comb begin
    free_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) free_idx = WAY_W'(w);
    end
  end

  assign way_idx = set_full ? ptr_q : free_idx;

  always_comb begin
    ptr_d = ptr_q;
    if (evict) begin
      ptr_d = (ptr_q == WAY_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/xlat_tlb_set.sv
module xlat_tlb_set #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm
);

  logic [WAYS-1:0]   valid_q, valid_d;
  logic [WAYS-1:0]   lk_match, fill_match, way_we;
  logic [TAG_W-1:0]  tag_q  [WAYS];
  logic [PPN_W-1:0]  ppn_q  [WAYS];
  logic [PERM_W-1:0] perm_q [WAYS];
  logic [WAY_W-1:0]  vic_idx;
  logic              refresh, evict;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match[w]   = valid_q[w] && (tag_q[w] == lk_tag);
    assign fill_match[w] = valid_q[w] && (tag_q[w] == fill_tag);

    always_ff @(posedge clk) begin
      if (way_we[w]) begin
        tag_q[w]  <= fill_tag;
        ppn_q[w]  <= fill_ppn;
        perm_q[w] <= fill_perm;
      end
    end
  end

  assign refresh = |fill_match;
  assign evict   = fill_en && !refresh && (&valid_q);

  xlat_tlb_victim #(.WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_q),
    .evict     (evict),
    .way_idx   (vic_idx)
  );

  always_comb begin
    way_we = '0;
    if (fill_en) begin
      if (refresh) way_we = fill_match;
      else         way_we[vic_idx] = 1'b1;
    end
  end

  always_comb begin
    if (flush) valid_d = '0;
    else       valid_d = valid_q | way_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        lk_ppn  = lk_ppn  | ppn_q[w];
        lk_perm = lk_perm | perm_q[w];
      end
    end
  end

  assign lk_hit = |lk_match;

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int PA_W   = 12,
  parameter int OFF_W  = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W = VPN_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              resp_prot_fault,
  output logic [PA_W-1:0]   resp_paddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_fault
);

  logic [VPN_W-1:0]  lk_vpn;
  logic [IDX_W-1:0]  lk_idx, fl_idx;
  logic [TAG_W-1:0]  lk_tag, fl_tag;
  logic              fill_go;

  logic [SETS-1:0]   set_hit;
  logic [PPN_W-1:0]  set_ppn  [SETS];
  logic [PERM_W-1:0] set_perm [SETS];

  logic              sel_hit, allow;
  logic [PPN_W-1:0]  sel_ppn;
  logic [PERM_W-1:0] sel_perm;

  assign lk_vpn  = req_vaddr[VA_W-1:OFF_W];
  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign fl_idx  = fill_vpn[IDX_W-1:0];
  assign fl_tag  = fill_vpn[VPN_W-1:IDX_W];
  assign fill_go = fill_valid && !fill_fault && !flush;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    xlat_tlb_set #(
      .WAYS   (WAYS),
      .TAG_W  (TAG_W),
      .PPN_W  (PPN_W),
      .PERM_W (PERM_W)
    ) u_set (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .lk_tag    (lk_tag),
      .fill_en   (fill_go && (fl_idx == IDX_W'(s))),
      .fill_tag  (fl_tag),
      .fill_ppn  (fill_ppn),
      .fill_perm (fill_perm),
      .lk_hit    (set_hit[s]),
      .lk_ppn    (set_ppn[s]),
      .lk_perm   (set_perm[s])
    );
  end

  assign sel_hit  = set_hit[lk_idx];
  assign sel_ppn  = set_ppn[lk_idx];
  assign sel_perm = set_perm[lk_idx];

  xlat_tlb_perm u_perm (
    .rights (sel_perm),
    .acc    (req_acc),
    .allow  (allow)
  );

  assign resp_hit        = req_valid && sel_hit && allow;
  assign resp_prot_fault = req_valid && sel_hit && !allow;
  assign resp_miss       = req_valid && !sel_hit;
  assign resp_paddr      = resp_hit ? {sel_ppn, req_vaddr[OFF_W-1:0]} : '0;

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              resp_hit,
  input logic              resp_miss,
  input logic              resp_prot_fault,
  input logic [PA_W-1:0]   resp_paddr,
  input logic              fill_valid,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic              fill_fault
);

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_hit, resp_miss, resp_prot_fault})); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(resp_hit || resp_miss || resp_prot_fault)); // R5

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> (resp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0])); // R2

  AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |-> (resp_paddr == '0)); // R3

  AST_DENY_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    resp_prot_fault |-> (resp_paddr == '0)); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (req_valid |-> resp_miss)); // R9

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_fault && !flush) |=>
      ((req_valid && (req_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))) |-> !resp_miss)); // R6

endmodule

bind xlat_tlb xlat_tlb_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush           (flush),
  .req_valid       (req_valid),
  .req_vaddr       (req_vaddr),
  .resp_hit        (resp_hit),
  .resp_miss       (resp_miss),
  .resp_prot_fault (resp_prot_fault),
  .resp_paddr      (resp_paddr),
  .fill_valid      (fill_valid),
  .fill_vpn        (fill_vpn),
  .fill_fault      (fill_fault)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        req_valid;
  logic [13:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        resp_hit, resp_miss, resp_prot_fault;
  logic [11:0] resp_paddr;
  logic        fill_valid;
  logic [7:0]  fill_vpn;
  logic [5:0]  fill_ppn;
  logic [2:0]  fill_perm;
  logic        fill_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference: per set, four slots plus a rotating pointer
  bit         m_v [4][4];
  logic [5:0] m_t [4][4];
  logic [5:0] m_p [4][4];
  logic [2:0] m_r [4][4];
  int         m_ptr [4];

  always #5 clk = ~clk;

  xlat_tlb dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_prot_fault(resp_prot_fault), .resp_paddr(resp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .fill_fault(fill_fault)
  );

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
    end
  endtask

  task automatic model_update(bit fv, logic [7:0] vpn, logic [5:0] ppn,
                              logic [2:0] perm, bit ff, bit fl);
    int s, w;
    if (fl) begin
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) m_v[a][b] = 1'b0;
      return;
    end
    if (!fv || ff) return;
    s = int'(vpn % 4);
    w = -1;
    for (int k = 0; k < 4; k++)
      if (w < 0 && m_v[s][k] && m_t[s][k] == vpn / 4) w = k;
    if (w < 0)
      for (int k = 0; k < 4; k++)
        if (w < 0 && !m_v[s][k]) w = k;
    if (w < 0) begin
      w = m_ptr[s];
      m_ptr[s] = (m_ptr[s] + 1) % 4;
    end
    m_v[s][w] = 1'b1;
    m_t[s][w] = vpn / 4;
    m_p[s][w] = ppn;
    m_r[s][w] = perm;
  endtask

  task automatic cyc(string lbl, bit rv, logic [13:0] va, logic [1:0] acc,
                     bit fv, logic [7:0] vpn, logic [5:0] ppn,
                     logic [2:0] perm, bit ff, bit fl);
    bit e_hit, e_miss, e_prot, found, ok;
    logic [11:0] e_pa;
    int s;
    logic [5:0] tg, pn;
    logic [2:0] rt;
    req_valid = rv; req_vaddr = va; req_acc = acc;
    fill_valid = fv; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
    fill_fault = ff; flush = fl;
    #2;
    e_hit = 0; e_miss = 0; e_prot = 0; e_pa = '0;
    if (rv) begin
      s = int'(va[7:6]);
      tg = va[13:8];
      found = 0; pn = '0; rt = '0;
      for (int k = 0; k < 4; k++)
        if (m_v[s][k] && m_t[s][k] == tg) begin
          found = 1; pn = m_p[s][k]; rt = m_r[s][k];
        end
      if (!found) e_miss = 1;
      else begin
        case (acc)
          2'd0: ok = rt[2];
          2'd1: ok = rt[1];
          2'd2: ok = rt[0];
          default: ok = 1'b0;
        endcase
        if (ok) begin e_hit = 1; e_pa = {pn, va[5:0]}; end
        else e_prot = 1;
      end
    end
    checks++;
    if (resp_hit !== e_hit || resp_miss !== e_miss ||
        resp_prot_fault !== e_prot || resp_paddr !== e_pa) begin
      errors++;
      $display("FAIL %s va=%h acc=%0d: got hit=%b miss=%b prot=%b pa=%h, expected hit=%b miss=%b prot=%b pa=%h",
               lbl, va, acc, resp_hit, resp_miss, resp_prot_fault, resp_paddr,
               e_hit, e_miss, e_prot, e_pa);
    end
    @(posedge clk);
    model_update(fv, vpn, ppn, perm, ff, fl);
    @(negedge clk);
  endtask

  task automatic look(string lbl, logic [13:0] va, logic [1:0] acc);
    cyc(lbl, 1'b1, va, acc, 1'b0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic fill(string lbl, logic [7:0] vpn, logic [5:0] ppn,
                      logic [2:0] perm, bit ff);
    cyc(lbl, 1'b0, '0, '0, 1'b1, vpn, ppn, perm, ff, 1'b0);
  endtask

  task automatic scan_set0(string lbl);
    for (int v = 0; v < 8; v++) look(lbl, {6'(v), 2'b00, 6'h05}, 2'd0);
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 0; req_valid = 0; req_vaddr = '0; req_acc = '0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0; fill_fault = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: empty after reset
    look("R10 reset empty", 14'h03d4, 2'd0);
    look("R10 reset empty", 14'h036b, 2'd0);

    // R6 R1 R2: install, then translate with offset carried through
    fill("R6 fill", 8'h0f, 6'h0d, 3'b110, 1'b0);
    look("R2 read hit 0x3d4", 14'h03d4, 2'd0);
    look("R2 write hit", 14'h03d4, 2'd1);
    look("R4 exec denied", 14'h03d4, 2'd2);
    fill("R6 fill", 8'h0d, 6'h2d, 3'b100, 1'b0);
    look("R1 R2 read hit 0x36b", 14'h036b, 2'd0);
    look("R4 write denied", 14'h036b, 2'd1);
    look("R4 reserved denied", 14'h036b, 2'd3);
    look("R1 other set misses", 14'h03ab, 2'd0);

    // R7: faulting fill installs nothing
    fill("R7 fault fill", 8'h0e, 6'h11, 3'b111, 1'b1);
    look("R7 still miss", 14'h038f, 2'd0);
    look("R3 miss", 14'h1234, 2'd0);

    // R5: idle request gives quiet outputs
    cyc("R5 idle", 1'b0, 14'h03d4, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0);

    // R4 execute-only page
    fill("R6 fill", 8'h21, 6'h3f, 3'b001, 1'b0);
    look("R4 exec hit", {8'h21, 6'h3c}, 2'd2);
    look("R4 read denied", {8'h21, 6'h3c}, 2'd0);

    // R8: fill set 0 beyond capacity
    for (int v = 0; v < 6; v++) fill("R8 fill set0", {6'(v), 2'b00}, 6'(v + 8), 3'b111, 1'b0);
    scan_set0("R8 round-robin victim");
    fill("R6 overwrite same tag", 8'h08, 6'h33, 3'b100, 1'b0);
    look("R6 overwrite visible", 14'h0207, 2'd0);
    look("R6 overwrite perm", 14'h0207, 2'd1);
    fill("R8 evict after overwrite", 8'h18, 6'h01, 3'b111, 1'b0);
    scan_set0("R8 pointer not moved by overwrite");

    // R9: flush with simultaneous fill
    cyc("R9 flush", 1'b0, '0, '0, 1'b1, 8'h20, 6'h05, 3'b111, 1'b0, 1'b1);
    look("R9 dropped fill", 14'h0800, 2'd0);
    look("R9 flushed", 14'h03d4, 2'd0);
    scan_set0("R9 flushed set0");
    for (int v = 0; v < 5; v++) fill("R9 refill", {6'(v + 1), 2'b00}, 6'(v + 20), 3'b111, 1'b0);
    scan_set0("R9 R8 pointer kept over flush");

    // same cycle fill and lookup of that page: old state seen
    cyc("R6 same-cycle", 1'b1, 14'h0fc0, 2'd0, 1'b1, 8'h3f, 6'h2a, 3'b111, 1'b0, 1'b0);
    look("R6 next-cycle", 14'h0fc0, 2'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule